// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM from the moment power and clock become valid to the idle state in which normal traffic can start. After reset it holds the clock enable and every byte mask high and presents no-operation commands for a stabilization window. The window is a number of microseconds, converted to clock cycles from a clock-frequency parameter. It then closes all banks with one precharge command. Next comes a parameterised train of auto-refresh commands, never fewer than eight. Last, it programs the mode register with a word assembled from four configuration inputs. A done flag rises once the mode-register recovery time has elapsed.

The configuration inputs are read in the cycle that carries the mode-register command. If any field holds a reserved code, the block writes a known-safe word instead: burst length 1, sequential order and CAS latency 3, with the requested write mode kept. It also raises a sticky error flag. Reserved codes include a full-page burst combined with interleaved order.

The controller is a single state machine with eight states. `HOLD` counts the stabilization window. `PRECH` issues precharge-all. `RP_WAIT` waits out the precharge recovery. `REFRESH` issues one auto-refresh. `RC_WAIT` waits out the refresh cycle time, then returns to `REFRESH` or, once the last refresh is done, moves to `MRS`. `MRS` issues the mode-register write. `RSC_WAIT` waits out the recovery time. `READY` raises the done flag and stays there until reset. Each command state lasts exactly one cycle. One down-counter times every wait.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While reset is held and for the first CLK_MHZ*STABLE_US cycles after its release, the command pins show NOP ({cs_n,ras_n,cas_n,we_n}=0111), init_done and config_error are 0.
- R2: The first command is precharge-all (0111→0010, address bit 10 high, other address bits and bank bits 0), issued exactly CLK_MHZ*STABLE_US cycles after reset release.
- R3: The first auto-refresh (0001) follows the precharge by exactly T_RP cycles.
- R4: Exactly max(N_REF,8) auto-refresh commands are issued, consecutive ones exactly T_RC cycles apart.
- R5: The mode-register command (0000) is issued exactly T_RC cycles after the last refresh and only once.
- R6: In the mode word, burst length sits on address bits 2:0, burst type on bit 3, CAS latency on bits 6:4 and write mode on bit 9; bits 7, 8, 10, 11 and both bank bits are 0.
- R7: Burst length codes 000, 001, 010 and 011 are legal, 111 (full page) is legal only with burst type 0; every other burst length code is reserved.
- R8: CAS latency codes 010 and 011 are legal; every other code is reserved. Write mode (0 burst, 1 single) has no reserved value.
- R9: With any reserved code, the mode word carries burst length 000, type 0, CAS latency 011 and the requested write mode; config_error rises one cycle after the mode command and stays high until reset.
- R10: init_done rises exactly T_RSC cycles after the mode command, stays high, and no command other than NOP follows.
- R11: sd_cke is 1 and every sd_dqm bit is 1 in every cycle of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_burst_len | input | 3 | Requested burst length code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | Requested CAS latency code |
| cfg_write_single | input | 1 | 0 burst writes, 1 single-location writes |
| sd_cke | output | 1 | Clock enable to the memory |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_dqm | output | DQM_W | Byte masks, held high |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 12 | Row/column address bus, carries the mode word |
| init_done | output | 1 | Memory initialized and idle |
| config_error | output | 1 | A reserved configuration code was replaced |

## Verification
Two decisions fall into the same cycle. The first is the end of the last refresh gap, where the counter reaching its limit must divert the machine to the mode command and not to one more refresh. The second is the mode command itself, where the word put on the address bus and the reserved-code judgement that sets config_error come from the same sampled inputs. Each run records every non-NOP command against the cycle count since reset release. A miscount at the refresh boundary therefore shows up as a ninth refresh or a shifted mode command. Five runs cover legal, full-page and three kinds of reserved configuration. In each run the address word and the error flag are compared against values computed in the bench.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    // command codes on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_PRECH,
        ST_RP_WAIT,
        ST_REFRESH,
        ST_RC_WAIT,
        ST_MRS,
        ST_RSC_WAIT,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic [2:0] bl;
        logic       bt;
        logic [2:0] cl;
        logic       wm;
    } mode_cfg_t;

endpackage

// File: rtl/sdr_gap_timer.sv
module sdr_gap_timer #(
    parameter int TW      = 17,
    parameter int RST_VAL = 99999
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            remain <= TW'(RST_VAL);
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    // a freshly loaded count never shows as expired in the following cycle
    p_load_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/sdr_mode_encoder.sv
module sdr_mode_encoder
    import sdram_init_pkg::*;
#(
    parameter int AW = 12
) (
    input  mode_cfg_t       cfg,
    output logic [AW-1:0]   word,
    output logic            cfg_bad
);

    logic bl_ok;
    logic cl_ok;
    mode_cfg_t eff;

    always_comb begin
        unique case (cfg.bl)
            3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
            3'b111:                         bl_ok = (cfg.bt == 1'b0);
            default:                        bl_ok = 1'b0;
        endcase
        cl_ok   = (cfg.cl == 3'b010) || (cfg.cl == 3'b011);
        cfg_bad = !(bl_ok && cl_ok);

        if (cfg_bad) begin
            eff.bl = 3'b000;
            eff.bt = 1'b0;
            eff.cl = 3'b011;
            eff.wm = cfg.wm;
        end else begin
            eff = cfg;
        end

        word      = '0;
        word[2:0] = eff.bl;
        word[3]   = eff.bt;
        word[6:4] = eff.cl;
        word[9]   = eff.wm;
    end

    // the word leaving this block never carries a reserved combination
    always_comb begin
        p_word_legal_r7: assert (!(word[2:0] inside {3'b100, 3'b101, 3'b110})
                                 && !(word[2:0] == 3'b111 && word[3]));
        p_cl_legal_r8: assert (word[6:4] == 3'b010 || word[6:4] == 3'b011);
    end

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ   = 200,
    parameter int STABLE_US = 500,
    parameter int T_RP      = 3,
    parameter int T_RC      = 9,
    parameter int T_RSC     = 2,
    parameter int N_REF     = 8,
    parameter int DQM_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_burst_len,
    input  logic             cfg_burst_type,
    input  logic [2:0]       cfg_cas_lat,
    input  logic             cfg_write_single,
    output logic             sd_cke,
    output logic             sd_cs_n,
    output logic             sd_ras_n,
    output logic             sd_cas_n,
    output logic             sd_we_n,
    output logic [DQM_W-1:0] sd_dqm,
    output logic [1:0]       sd_ba,
    output logic [11:0]      sd_addr,
    output logic             init_done,
    output logic             config_error
);

    localparam int STABLE_CYC = (CLK_MHZ * STABLE_US < 2) ? 2 : CLK_MHZ * STABLE_US;
    localparam int RP_GAP     = (T_RP  < 2) ? 2 : T_RP;
    localparam int RC_GAP     = (T_RC  < 2) ? 2 : T_RC;
    localparam int RSC_GAP    = (T_RSC < 2) ? 2 : T_RSC;
    localparam int REF_CNT    = (N_REF < 8) ? 8 : N_REF;
    localparam int GAP_MAX    = (RP_GAP > RC_GAP) ? ((RP_GAP > RSC_GAP) ? RP_GAP : RSC_GAP)
                                                  : ((RC_GAP > RSC_GAP) ? RC_GAP : RSC_GAP);
    localparam int CNT_MAX    = (STABLE_CYC > GAP_MAX) ? STABLE_CYC : GAP_MAX;
    localparam int TW         = $clog2(CNT_MAX + 1);
    localparam int RW         = $clog2(REF_CNT + 1);

    init_state_e   state, state_nx;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic [RW-1:0] ref_cnt;
    sd_cmd_e       cmd;
    mode_cfg_t     cfg;
    logic [11:0]   mode_word;
    logic          mode_bad;

    assign cfg = '{bl: cfg_burst_len, bt: cfg_burst_type,
                   cl: cfg_cas_lat,   wm: cfg_write_single};

    sdr_mode_encoder #(.AW(12)) u_mode (
        .cfg     (cfg),
        .word    (mode_word),
        .cfg_bad (mode_bad)
    );

    // every wait is timed by one shared down-counter, loaded in command states
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_PRECH:   begin tmr_load = 1'b1; tmr_val = TW'(RP_GAP - 2);  end
            ST_REFRESH: begin tmr_load = 1'b1; tmr_val = TW'(RC_GAP - 2);  end
            ST_MRS:     begin tmr_load = 1'b1; tmr_val = TW'(RSC_GAP - 2); end
            default:    ;
        endcase
    end

    sdr_gap_timer #(.TW(TW), .RST_VAL(STABLE_CYC - 1)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD:     if (tmr_done) state_nx = ST_PRECH;
            ST_PRECH:    state_nx = ST_RP_WAIT;
            ST_RP_WAIT:  if (tmr_done) state_nx = ST_REFRESH;
            ST_REFRESH:  state_nx = ST_RC_WAIT;
            ST_RC_WAIT:  if (tmr_done)
                             state_nx = (ref_cnt == RW'(REF_CNT)) ? ST_MRS : ST_REFRESH;
            ST_MRS:      state_nx = ST_RSC_WAIT;
            ST_RSC_WAIT: if (tmr_done) state_nx = ST_READY;
            ST_READY:    state_nx = ST_READY;
            default:     state_nx = ST_HOLD;
        endcase
    end

    // state register with refresh count and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state        <= ST_HOLD;
            ref_cnt      <= '0;
            config_error <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_REFRESH)
                ref_cnt <= ref_cnt + 1'b1;
            if (state == ST_MRS && mode_bad)
                config_error <= 1'b1;
        end
    end

    // outputs decoded from the current state
    always_comb begin
        cmd       = CMD_NOP;
        sd_addr   = '0;
        sd_ba     = '0;
        init_done = 1'b0;
        unique case (state)
            ST_PRECH:   begin cmd = CMD_PRE; sd_addr[10] = 1'b1; end
            ST_REFRESH: cmd = CMD_REF;
            ST_MRS:     begin cmd = CMD_MRS; sd_addr = mode_word; end
            ST_READY:   init_done = 1'b1;
            default:    ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = 1'b1;
    assign sd_dqm = '1;

    // mode command is issued once and only after the full refresh train
    logic mrs_seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               mrs_seen <= 1'b0;
        else if (cmd == CMD_MRS)  mrs_seen <= 1'b1;
    end

    p_mrs_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> !mrs_seen);
    p_ref_total_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> (ref_cnt == RW'(REF_CNT)));
    p_done_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == CMD_NOP) && mrs_seen);
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        config_error |=> config_error);
    p_pre_all_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> $past(state) == ST_HOLD);

endmodule

// File: tb/sdram_pwrup_seq_test.sv
`timescale 1ns/1ps
module sdram_pwrup_seq_test;

    localparam int CLK_MHZ   = 200;
    localparam int STABLE_US = 2;
    localparam int T_RP      = 3;
    localparam int T_RC      = 7;
    localparam int T_RSC     = 2;
    localparam int N_REF     = 8;
    localparam int DQM_W     = 8;
    localparam int S_CYC     = CLK_MHZ * STABLE_US;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [11:0] addr;
        logic [31:0] cyc;
    } exp_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_burst_len = '0;
    logic             cfg_burst_type = 1'b0;
    logic [2:0]       cfg_cas_lat = 3'b011;
    logic             cfg_write_single = 1'b0;
    logic             sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [DQM_W-1:0] sd_dqm;
    logic [1:0]       sd_ba;
    logic [11:0]      sd_addr;
    logic             init_done, config_error;

    always #2.5 clk = ~clk;

    sdram_pwrup_seq #(
        .CLK_MHZ(CLK_MHZ), .STABLE_US(STABLE_US), .T_RP(T_RP), .T_RC(T_RC),
        .T_RSC(T_RSC), .N_REF(N_REF), .DQM_W(DQM_W)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_burst_len(cfg_burst_len), .cfg_burst_type(cfg_burst_type),
        .cfg_cas_lat(cfg_cas_lat), .cfg_write_single(cfg_write_single),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_dqm(sd_dqm),
        .sd_ba(sd_ba), .sd_addr(sd_addr),
        .init_done(init_done), .config_error(config_error)
    );

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    int          cyc = 0;
    exp_item_t   exp_q[$];
    int          exp_done_cyc = 0;
    int          exp_err_cyc = 0;
    bit          exp_bad = 0;
    bit          done_seen = 0;
    bit          err_seen = 0;
    bit          finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // monitor: pops expected commands as the design issues them
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] c;
            c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            check(sd_cke === 1'b1 && sd_dqm === '1, "R11", "cke/dqm high",
                  {sd_cke, sd_dqm}, {1'b1, {DQM_W{1'b1}}});
            if (c !== 4'b0111) begin
                if (exp_q.size() == 0) begin
                    check(0, "R10", "unexpected command after sequence", c, 7);
                end else begin
                    exp_item_t e;
                    e = exp_q.pop_front();
                    check(c === e.cmd, "R4", "command code", c, e.cmd);
                    check(cyc == int'(e.cyc), "R3", "command cycle", cyc, e.cyc);
                    check(sd_addr === e.addr, "R6", "address word", sd_addr, e.addr);
                    check(sd_ba === e.ba, "R6", "bank bits", sd_ba, e.ba);
                end
            end
            if (init_done && !done_seen) begin
                done_seen = 1;
                check(cyc == exp_done_cyc, "R10", "init_done rise cycle", cyc, exp_done_cyc);
            end
            if (done_seen)
                check(init_done === 1'b1, "R10", "init_done held", init_done, 1);
            if (config_error && !err_seen) begin
                err_seen = 1;
                check(exp_bad && cyc == exp_err_cyc, "R9", "config_error rise cycle",
                      cyc, exp_bad ? exp_err_cyc : -1);
            end
        end
    end

    // driver: builds the expected command list for one configuration and runs it
    task automatic run_case(input logic [2:0] bl, input logic bt,
                            input logic [2:0] cl, input logic wm, input bit bad);
        exp_item_t   it;
        logic [11:0] w;
        int          ref_total;
        int          t;
        @(negedge clk);
        rst_n = 1'b0;
        cfg_burst_len = bl; cfg_burst_type = bt;
        cfg_cas_lat = cl;   cfg_write_single = wm;
        exp_q.delete();
        done_seen = 0; err_seen = 0; exp_bad = bad;
        @(negedge clk);
        check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} === 4'b0111, "R1",
              "NOP in reset", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
        check(init_done === 1'b0 && config_error === 1'b0, "R1", "flags low in reset",
              {init_done, config_error}, 0);

        ref_total = (N_REF < 8) ? 8 : N_REF;
        it = '{cmd: 4'b0010, ba: 2'b00, addr: 12'h400, cyc: 32'(S_CYC)};
        exp_q.push_back(it);
        t = S_CYC + T_RP;
        for (int i = 0; i < ref_total; i++) begin
            it = '{cmd: 4'b0001, ba: 2'b00, addr: 12'h000, cyc: 32'(t)};
            exp_q.push_back(it);
            t = t + T_RC;
        end
        w = '0;
        if (bad) begin
            w[2:0] = 3'b000; w[3] = 1'b0; w[6:4] = 3'b011;
        end else begin
            w[2:0] = bl; w[3] = bt; w[6:4] = cl;
        end
        w[9] = wm;
        it = '{cmd: 4'b0000, ba: 2'b00, addr: w, cyc: 32'(t)};
        exp_q.push_back(it);
        exp_done_cyc = t + T_RSC;
        exp_err_cyc  = t + 1;

        rst_n = 1'b1;
        // R1: stabilization window stays quiet; checked by the monitor since
        // the first expected command is the precharge at S_CYC
        while (cyc < exp_done_cyc + 20) @(negedge clk);
        check(exp_q.size() == 0, "R5", "commands left unissued", exp_q.size(), 0);
        check(done_seen, "R10", "init_done seen", done_seen, 1);
        check(config_error === bad, "R9", "config_error final", config_error, bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_case(3'b010, 1'b0, 3'b011, 1'b0, 0);  // R6: BL4 sequential CL3
        run_case(3'b111, 1'b0, 3'b010, 1'b1, 0);  // R7: full page sequential legal
        run_case(3'b111, 1'b1, 3'b010, 1'b0, 1);  // R7: full page interleaved reserved
        run_case(3'b001, 1'b1, 3'b001, 1'b1, 1);  // R8: CAS latency reserved
        run_case(3'b100, 1'b0, 3'b011, 1'b0, 1);  // R9: burst length reserved
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule